// File: doc/BRIEF.md
# Interrupt Aggregator with Message Doorbell

This block collects sixty-four interrupt sources into one level-sensitive request line for a parent interrupt controller. The lowest sources arrive on dedicated wires and are level-sensitive, active high. The remaining sources carry no wire. A bus master raises one of them by writing its interrupt number into a doorbell register, so each such source is a one-shot event.

Every source owns a pending (cause) bit and an enable-inhibit (mask) bit. Both sit in a shared register space of 32-bit words. Source n lives in word n/32 at bit n%32. Software scans the cause words to find pending sources and clears them by writing ones. It masks or unmasks a source with a read-modify-write of a mask word. The request line is high whenever some pending source is unmasked.

The register port is a plain synchronous interface with address, write enable, write data, read enable and read data. Read data is registered: it is valid in the cycle after the read enable.

Top module: `irq_doorbell_agg`

## Requirements
- R1: After reset every cause bit is 0, every mask bit is 1 and `irq_o` is low.
- R2: Cause word k is at byte offset 0x00+4k and mask word k is at byte offset 0x20+4k. The doorbell is at 0x30. Source n is bit n%32 of word n/32. Reading any other offset returns zero. `rd_data` presents the addressed word in the cycle after `rd_en`.
- R3: A mask word stores the value written to it and reads it back unchanged. Mask words change only on a write to their own offset.
- R4: Writing a 1 to a cause bit clears it. Writing a 0 leaves it as it was.
- R5: A doorbell write of a value N with 21 <= N <= 63 sets cause bit N.
- R6: A doorbell write of a value below 21 or above 63 is ignored; bits 5:0 alone do not decide the index. No cause bit changes.
- R7: Wired input w (0..20) passes through two synchroniser flops. While the input is high, cause bit w is set from the third rising clock edge on. The bit stays set after the input falls, until software clears it.
- R8: When a clear and a set of the same wired bit fall in one cycle, the set wins. An input held high therefore keeps its cause bit set through a clear write.
- R9: `irq_o` is high exactly when some cause bit is 1 and its mask bit is 0.
- R10: Writing all ones to both cause words and both mask words, with all wired inputs low, leaves nothing pending and `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wired_i | input | 21 | Level-sensitive wired sources 0..20, asynchronous |
| reg_addr | input | 8 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Aggregated level interrupt request |

## Verification
The assertions assume one register access per cycle, so a doorbell write and a cause clear never coincide. They also assume that the message-range cause bits can change only through the register port. The bench keeps within this because its write and read tasks each hold a single strobe for exactly one cycle. It changes the wired inputs only on falling edges, and waits out the synchroniser depth before it reads the cause words.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int SRC_COUNT   = 64;
    localparam int WIRED_COUNT = 21;
    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int CAUSE_BASE  = 'h00;
    localparam int MASK_BASE   = 'h20;
    localparam int DOORBELL_AT = 'h30;
endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int WIDTH = irq_agg_pkg::WIRED_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;
endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs #(
    parameter int SRC_COUNT   = irq_agg_pkg::SRC_COUNT,
    parameter int WIRED_COUNT = irq_agg_pkg::WIRED_COUNT,
    parameter int WORD_W      = irq_agg_pkg::WORD_W,
    parameter int ADDR_W      = irq_agg_pkg::ADDR_W,
    parameter int CAUSE_BASE  = irq_agg_pkg::CAUSE_BASE,
    parameter int MASK_BASE   = irq_agg_pkg::MASK_BASE,
    parameter int DOORBELL_AT = irq_agg_pkg::DOORBELL_AT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WIRED_COUNT-1:0] wired_sync,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   wr_en,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic                   rd_en,
    output logic [WORD_W-1:0]      rd_data,
    output logic [SRC_COUNT-1:0]   cause_o,
    output logic [SRC_COUNT-1:0]   mask_o
);
    localparam int WORDS = SRC_COUNT / WORD_W;
    localparam int IDX_W = $clog2(SRC_COUNT);

    typedef struct packed {
        logic [SRC_COUNT-1:0] cause;
        logic [SRC_COUNT-1:0] mask;
        logic [WORD_W-1:0]    rdata;
    } regs_t;

    regs_t                r_d, r_q;
    logic [SRC_COUNT-1:0] set_vec;
    logic [SRC_COUNT-1:0] clr_vec;
    logic                 db_hit;
    logic                 db_valid;
    logic [WORD_W-1:0]    rd_mux;

    assign db_hit   = wr_en && (reg_addr == ADDR_W'(DOORBELL_AT));
    assign db_valid = (wr_data >= WORD_W'(WIRED_COUNT)) && (wr_data < WORD_W'(SRC_COUNT));

    always_comb begin
        r_d     = r_q;
        set_vec = '0;
        clr_vec = '0;
        rd_mux  = '0;
        set_vec[WIRED_COUNT-1:0] = wired_sync;
        if (db_hit && db_valid) set_vec[wr_data[IDX_W-1:0]] = 1'b1;
        for (int k = 0; k < WORDS; k++) begin
            if (wr_en && reg_addr == ADDR_W'(CAUSE_BASE + 4 * k))
                clr_vec[k*WORD_W +: WORD_W] = wr_data;
            if (wr_en && reg_addr == ADDR_W'(MASK_BASE + 4 * k))
                r_d.mask[k*WORD_W +: WORD_W] = wr_data;
            if (reg_addr == ADDR_W'(CAUSE_BASE + 4 * k))
                rd_mux = r_q.cause[k*WORD_W +: WORD_W];
            if (reg_addr == ADDR_W'(MASK_BASE + 4 * k))
                rd_mux = r_q.mask[k*WORD_W +: WORD_W];
        end
        // set is applied after clear, so a same-cycle set survives
        r_d.cause = (r_q.cause & ~clr_vec) | set_vec;
        if (rd_en) r_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.cause <= '0;
            r_q.mask  <= '1;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.rdata;
    assign cause_o = r_q.cause;
    assign mask_o  = r_q.mask;

    a_r3_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(r_q.mask));

    a_r4_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_W'(CAUSE_BASE)) |=>
        ((r_q.cause[WORD_W-1:0] & $past(wr_data & ~set_vec[WORD_W-1:0])) == '0));

    a_r5_doorbell_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (db_hit && db_valid) |=> r_q.cause[$past(wr_data[IDX_W-1:0])]);

    a_r6_doorbell_range: assert property (@(posedge clk) disable iff (!rst_n)
        (db_hit && !db_valid) |=> $stable(r_q.cause[SRC_COUNT-1:WIRED_COUNT]));

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((r_q.cause[WIRED_COUNT-1:0] & $past(wired_sync)) == $past(wired_sync)));
endmodule

// File: rtl/irq_doorbell_agg.sv
module irq_doorbell_agg #(
    parameter int SRC_COUNT   = irq_agg_pkg::SRC_COUNT,
    parameter int WIRED_COUNT = irq_agg_pkg::WIRED_COUNT,
    parameter int WORD_W      = irq_agg_pkg::WORD_W,
    parameter int ADDR_W      = irq_agg_pkg::ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [WIRED_COUNT-1:0] wired_i,
    input  logic [ADDR_W-1:0]      reg_addr,
    input  logic                   wr_en,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic                   rd_en,
    output logic [WORD_W-1:0]      rd_data,
    output logic                   irq_o
);
    logic [WIRED_COUNT-1:0] wired_sync;
    logic [SRC_COUNT-1:0]   cause;
    logic [SRC_COUNT-1:0]   mask;

    irq_agg_sync #(.WIDTH(WIRED_COUNT)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (wired_i),
        .sync_o  (wired_sync)
    );

    irq_agg_regs #(
        .SRC_COUNT   (SRC_COUNT),
        .WIRED_COUNT (WIRED_COUNT),
        .WORD_W      (WORD_W),
        .ADDR_W      (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wired_sync (wired_sync),
        .reg_addr   (reg_addr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .cause_o    (cause),
        .mask_o     (mask)
    );

    assign irq_o = |(cause & ~mask);

    a_r9_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_o);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq_o);
endmodule

// File: tb/irq_doorbell_agg_tb.sv
module irq_doorbell_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] wired_i = '0;
    logic [7:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_doorbell_agg u_dut (
        .clk(clk), .rst_n(rst_n), .wired_i(wired_i), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        rd(8'h00, v); chk("R1 cause0", v, 32'h0);
        rd(8'h04, v); chk("R1 cause1", v, 32'h0);
        rd(8'h20, v); chk("R1 mask0", v, 32'hFFFF_FFFF);
        rd(8'h24, v); chk("R1 mask1", v, 32'hFFFF_FFFF);
        // R2 undefined offsets read zero
        wr(8'h30, 32'd40);
        for (int a = 0; a < 64; a += 4) begin
            if (a != 'h00 && a != 'h04 && a != 'h20 && a != 'h24) begin
                rd(8'(a), v); chk("R2 undefined offset", v, 32'h0);
            end
        end
        wr(8'h04, 32'hFFFF_FFFF);
        // R3 mask store and readback
        wr(8'h20, 32'hA5C3_0F96);
        wr(8'h24, 32'h5A3C_F069);
        rd(8'h20, v); chk("R3 mask0", v, 32'hA5C3_0F96);
        rd(8'h24, v); chk("R3 mask1", v, 32'h5A3C_F069);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        // R5/R6/R9/R4 doorbell sweep over all 64 numbers
        for (int n = 0; n < 64; n++) begin
            logic [31:0] bitv;
            logic        valid;
            logic [7:0]  ca, ma;
            bitv  = 32'd1 << (n % 32);
            valid = (n >= 21);
            ca    = 8'((n / 32) * 4);
            ma    = 8'('h20 + (n / 32) * 4);
            wr(8'h30, 32'(n));
            rd(ca, v); chk(valid ? "R5 doorbell set" : "R6 low number ignored", v, valid ? bitv : 32'h0);
            rd(8'(((1 - n / 32)) * 4), v); chk("R2 other word untouched", v, 32'h0);
            chk("R9 masked quiet", {31'd0, irq_o}, 32'd0);
            wr(ma, ~bitv);
            chk("R9 unmasked request", {31'd0, irq_o}, {31'd0, valid});
            wr(ma, 32'hFFFF_FFFF);
            wr(ca, 32'h0);
            rd(ca, v); chk("R4 zero write no effect", v, valid ? bitv : 32'h0);
            wr(ca, bitv);
            rd(ca, v); chk("R4 one write clears", v, 32'h0);
        end
        // R6 out-of-range high values
        wr(8'h30, 32'd64);
        wr(8'h30, 32'd100);
        wr(8'h30, 32'hFFFF_FFFF);
        wr(8'h30, 32'h0000_0075);
        rd(8'h00, v); chk("R6 high ignored word0", v, 32'h0);
        rd(8'h04, v); chk("R6 high ignored word1", v, 32'h0);
        // R7/R8 wired sweep
        for (int w = 0; w < 21; w++) begin
            wired_i = 21'd1 << w;
            @(negedge clk);
            @(negedge clk);
            rd(8'h00, v); chk("R7 not before third edge", v, 32'h0);
            rd(8'h00, v); chk("R7 wired level sets", v, 32'd1 << w);
            wr(8'h00, 32'd1 << w);
            rd(8'h00, v); chk("R8 set beats clear", v, 32'd1 << w);
            wired_i = '0;
            repeat (4) @(negedge clk);
            rd(8'h00, v); chk("R7 sticky after release", v, 32'd1 << w);
            wr(8'h00, 32'd1 << w);
            rd(8'h00, v); chk("R7 cleared after release", v, 32'h0);
        end
        // R9 wired source unmasked
        wired_i = 21'd1 << 5;
        repeat (4) @(negedge clk);
        chk("R9 masked wired", {31'd0, irq_o}, 32'd0);
        wr(8'h20, ~(32'd1 << 5));
        chk("R9 wired request", {31'd0, irq_o}, 32'd1);
        wired_i = '0;
        // R10 init sequence
        wr(8'h30, 32'd22);
        wr(8'h30, 32'd50);
        wr(8'h24, 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 pending unmasked", {31'd0, irq_o}, 32'd1);
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R10 cause0", v, 32'h0);
        rd(8'h04, v); chk("R10 cause1", v, 32'h0);
        rd(8'h24, v); chk("R10 mask1", v, 32'hFFFF_FFFF);
        chk("R10 irq", {31'd0, irq_o}, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule